// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is a small byte-wide serial port attached to a 32-bit register bus. Software writes a byte to the data register and the block sends it on `tx_o` as a frame of one low start bit, eight data bits sent least significant bit first, and one high stop bit. A receiver watches `rx_i`, rebuilds frames of the same shape, and holds one byte for software to read. Every bit lasts a whole number of clock cycles set by a 21-bit divisor register. Transmit and receive each hold exactly one byte. A second byte that arrives while the first is still held is lost, and an overrun flag records the loss.

The bus is a plain strobe interface. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`, and a read strobe on the data register consumes the received byte. Four event flags (transmit buffer drained, byte received, transmit overrun, receive overrun) are cleared by writing one to them. Each flag drives its own interrupt pin through its own enable bit, and one more pin is the OR of those four pins.

The transmitter has four states. IDLE goes to START when TX is enabled and a byte is held (load). START goes to DATA after one bit time. DATA goes to STOP after the last data bit. STOP goes back to START if another byte is held and TX is enabled, and to IDLE otherwise. The receiver also has four states. IDLE goes to START on a falling edge of the synchronised line while RX is enabled. START goes to DATA if the line is still low at half a bit time, and back to IDLE if it is not (a false start). DATA goes to STOP after the last data bit is sampled. STOP goes to IDLE after the stop bit is sampled, and the byte is delivered only if the stop bit reads high.

Top module: `serlink_uart`

## Requirements
- R1: After reset, CTRL, STATE and INT read 0, the divisor reads 16, `tx_o` is high and every interrupt pin is low.
- R2: Register offsets are DATA 0x00, STATE 0x04, CTRL 0x08, INT 0x0C and divisor 0x10. CTRL keeps bits [5:0] and the divisor keeps bits [20:0]. Higher bits read as zero.
- R3: When CTRL bit 0 (TX enable) is set, a byte written to DATA is sent as a start bit (0), eight data bits least significant bit first, and a stop bit (1). Each bit lasts exactly divisor cycles. The start bit begins on the clock edge after the write edge.
- R4: STATE bit 0 (TX full) is set by a DATA write and clears when the byte moves into the shifter. While CTRL bit 0 is clear, the byte stays held and `tx_o` stays high.
- R5: A DATA write while STATE bit 0 is set discards the new byte and sets STATE bit 2 and INT bit 2. The byte already held is the one that is sent.
- R6: INT bit 0 is set when the held transmit byte moves into the shifter.
- R7: When CTRL bit 1 (RX enable) is set, a valid frame on `rx_i` sets STATE bit 1 (RX full) and INT bit 1. A bus read of DATA then returns the byte and clears STATE bit 1.
- R8: A frame whose stop bit samples low is discarded. STATE bit 1 and INT bit 1 stay clear.
- R9: A frame that completes while STATE bit 1 is set is dropped. The held byte is kept, and STATE bit 3 and INT bit 3 are set.
- R10: While CTRL bit 1 is clear, frames on `rx_i` are ignored.
- R11: Writing one to an INT bit clears that bit, and writing zero leaves it unchanged. STATE bits 2 and 3 clear the same way and otherwise stay set.
- R12: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` are INT bits 0 to 3, each ANDed with CTRL bits 2 to 5 in that order. `irq_any` is high exactly when one of those four pins is high.
- R13: If the line is back high at half a bit time after a falling edge, the receiver returns to idle without delivering a byte, and the next valid frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-drained interrupt |
| irq_rx | output | 1 | Byte-received interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupt pins |

## Verification
Register and flag effects of a bus write can be seen at the first falling clock edge after the write edge. The bench reads them there or later, never at the edge itself. A byte written to DATA, or an existing byte released by setting TX enable, moves into the shifter one edge later, and the start bit drives `tx_o` from that edge on. The bench therefore samples each bit of a transmitted frame at half a bit time plus one cycle after the write, and then once every divisor cycles. A received byte is flagged about nine and a half bit times after the start edge, plus three cycles for synchronisation and edge detection, so the bench reads STATE only after the whole driven frame plus a few cycles.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

    // Register byte offsets
    localparam int OFS_DATA  = 'h00;
    localparam int OFS_STATE = 'h04;
    localparam int OFS_CTRL  = 'h08;
    localparam int OFS_INT   = 'h0C;
    localparam int OFS_DIV   = 'h10;

    // Control register, bit 0 at the bottom
    typedef struct packed {
        logic rxovr_ie;   // bit 5
        logic txovr_ie;   // bit 4
        logic rx_ie;      // bit 3
        logic tx_ie;      // bit 2
        logic rx_en;      // bit 1
        logic tx_en;      // bit 0
    } ctrl_t;

    // Event flags (INT register and the overrun part of STATE)
    typedef struct packed {
        logic rx_ovr;     // bit 3
        logic tx_ovr;     // bit 2
        logic rx;         // bit 1
        logic tx;         // bit 0
    } evt_t;

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_e;

endpackage

// File: rtl/serlink_tx.sv
module serlink_tx
    import serlink_pkg::*;
#(
    parameter int DIV_W     = 21,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div,
    input  logic                 pend,
    input  logic [DATA_BITS-1:0] byte_i,
    output logic                 take,
    output logic                 line
);

    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    tx_state_e            state_q, state_d;
    logic [DIV_W-1:0]     cnt_q, cnt_d;
    logic [BIT_W-1:0]     bit_q, bit_d;
    logic [DATA_BITS-1:0] shf_q, shf_d;
    logic                 line_q;
    logic                 bit_end, last_bit, load;

    assign bit_end  = (cnt_q == div - DIV_W'(1));
    assign last_bit = (bit_q == BIT_W'(DATA_BITS - 1));
    assign load     = en && pend &&
                      ((state_q == TX_IDLE) || (state_q == TX_STOP && bit_end));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && last_bit) state_d = TX_STOP;
            TX_STOP: begin
                if (load)         state_d = TX_START;
                else if (bit_end) state_d = TX_IDLE;
            end
            default:  state_d = TX_IDLE;
        endcase
    end

    // Bit timer, bit index and shifter
    always_comb begin
        cnt_d = cnt_q + DIV_W'(1);
        bit_d = bit_q;
        shf_d = shf_q;
        if (load) begin
            cnt_d = '0;
            bit_d = '0;
            shf_d = byte_i;
        end else if (state_q == TX_IDLE) begin
            cnt_d = '0;
        end else if (bit_end) begin
            cnt_d = '0;
            if (state_q == TX_DATA) begin
                bit_d = bit_q + BIT_W'(1);
                shf_d = shf_q >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            shf_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            bit_q <= bit_d;
            shf_q <= shf_d;
        end
    end

    // Registered line output, follows the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            unique case (state_d)
                TX_START: line_q <= 1'b0;
                TX_DATA:  line_q <= shf_d[0];
                default:  line_q <= 1'b1;
            endcase
        end
    end

    assign take = load;
    assign line = line_q;

endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
    import serlink_pkg::*;
#(
    parameter int DIV_W       = 21,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div,
    input  logic                 rx_i,
    output logic                 done,
    output logic [DATA_BITS-1:0] byte_o
);

    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rx_s, fall;

    // Input synchroniser, depth chosen by parameter
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_i;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
            end
        end
    endgenerate

    assign rx_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= rx_s;
    end

    assign fall = prev_q && !rx_s;

    rx_state_e            state_q, state_d;
    logic [DIV_W-1:0]     cnt_q, cnt_d;
    logic [BIT_W-1:0]     bit_q, bit_d;
    logic [DATA_BITS-1:0] shf_q, shf_d;
    logic                 done_q;
    logic                 half_end, full_end, last_bit, samp;

    assign half_end = (cnt_q == (div >> 1) - DIV_W'(1));
    assign full_end = (cnt_q == div - DIV_W'(1));
    assign last_bit = (bit_q == BIT_W'(DATA_BITS - 1));

    always_comb begin
        unique case (state_q)
            RX_START:         samp = half_end;
            RX_DATA, RX_STOP: samp = full_end;
            default:          samp = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (en && fall) state_d = RX_START;
            RX_START: if (samp) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (samp && last_bit) state_d = RX_STOP;
            RX_STOP:  if (samp) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // Timer, bit index and shifter
    always_comb begin
        cnt_d = (state_q == RX_IDLE || samp) ? '0 : cnt_q + DIV_W'(1);
        bit_d = bit_q;
        shf_d = shf_q;
        if (state_q == RX_START) begin
            bit_d = '0;
        end else if (state_q == RX_DATA && samp) begin
            bit_d = bit_q + BIT_W'(1);
            shf_d = {rx_s, shf_q[DATA_BITS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            shf_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            bit_q <= bit_d;
            shf_q <= shf_d;
        end
    end

    // Output: one-cycle delivery pulse for a frame with a high stop bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == RX_STOP) && samp && rx_s;
    end

    assign done   = done_q;
    assign byte_o = shf_q;

endmodule

// File: rtl/serlink_regs.sv
module serlink_regs
    import serlink_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int DIV_W     = 21,
    parameter int DIV_RESET = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 tx_take,
    input  logic                 rx_done,
    input  logic [DATA_BITS-1:0] rx_byte,
    output ctrl_t                ctrl,
    output logic [DIV_W-1:0]     div,
    output logic                 tx_pend,
    output logic [DATA_BITS-1:0] tx_byte,
    output evt_t                 flags
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int EVT_W  = $bits(evt_t);

    ctrl_t                ctrl_q;
    logic [DIV_W-1:0]     div_q;
    logic                 tx_full_q, rx_full_q;
    logic [DATA_BITS-1:0] tx_hold_q, rx_buf_q;
    logic                 tx_ovr_q, rx_ovr_q;
    evt_t                 int_q, int_d, evt;

    logic wr_data, wr_state, wr_ctrl, wr_int, wr_div, rd_data;
    logic tx_push, rx_load;
    evt_t clr_mask;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:DIV_W];

    assign wr_data  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_DATA));
    assign wr_state = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_STATE));
    assign wr_ctrl  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_int   = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_INT));
    assign wr_div   = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_DIV));
    assign rd_data  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_DATA));

    assign clr_mask = evt_t'(bus_wdata[EVT_W-1:0]);

    assign tx_push  = wr_data && !tx_full_q;
    assign rx_load  = rx_done && !rx_full_q;

    // Events that raise flags this cycle
    assign evt.tx     = tx_take;
    assign evt.rx     = rx_load;
    assign evt.tx_ovr = wr_data && tx_full_q;
    assign evt.rx_ovr = rx_done && rx_full_q;

    // A new event wins over a same-cycle clear
    assign int_d = evt | (int_q & ~(wr_int ? clr_mask : evt_t'('0)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            div_q     <= DIV_W'(DIV_RESET);
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
            tx_hold_q <= '0;
            rx_buf_q  <= '0;
            tx_ovr_q  <= 1'b0;
            rx_ovr_q  <= 1'b0;
            int_q     <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];

            if (tx_push) begin
                tx_full_q <= 1'b1;
                tx_hold_q <= bus_wdata[DATA_BITS-1:0];
            end else if (tx_take) begin
                tx_full_q <= 1'b0;
            end

            if (rx_load) begin
                rx_full_q <= 1'b1;
                rx_buf_q  <= rx_byte;
            end else if (rd_data) begin
                rx_full_q <= 1'b0;
            end

            tx_ovr_q <= evt.tx_ovr || (tx_ovr_q && !(wr_state && clr_mask.tx_ovr));
            rx_ovr_q <= evt.rx_ovr || (rx_ovr_q && !(wr_state && clr_mask.rx_ovr));
            int_q    <= int_d;
        end
    end

    // Read data
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DATA):  bus_rdata = DATA_W'(rx_buf_q);
            ADDR_W'(OFS_STATE): bus_rdata = DATA_W'({rx_ovr_q, tx_ovr_q, rx_full_q, tx_full_q});
            ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_INT):   bus_rdata = DATA_W'(int_q);
            ADDR_W'(OFS_DIV):   bus_rdata = DATA_W'(div_q);
            default:            bus_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign div     = div_q;
    assign tx_pend = tx_full_q;
    assign tx_byte = tx_hold_q;
    assign flags   = int_q;

endmodule

// File: rtl/serlink_uart.sv
module serlink_uart
    import serlink_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int DIV_W       = 21,
    parameter int DIV_RESET   = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_i,
    output logic              tx_o,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_txovr,
    output logic              irq_rxovr,
    output logic              irq_any
);

    ctrl_t                ctrl;
    evt_t                 flags;
    logic [DIV_W-1:0]     div;
    logic                 tx_pend, tx_take, rx_done;
    logic [DATA_BITS-1:0] tx_byte, rx_byte;

    serlink_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET),
        .DATA_BITS (DATA_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_take   (tx_take),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .div       (div),
        .tx_pend   (tx_pend),
        .tx_byte   (tx_byte),
        .flags     (flags)
    );

    serlink_tx #(
        .DIV_W     (DIV_W),
        .DATA_BITS (DATA_BITS)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl.tx_en),
        .div    (div),
        .pend   (tx_pend),
        .byte_i (tx_byte),
        .take   (tx_take),
        .line   (tx_o)
    );

    serlink_rx #(
        .DIV_W       (DIV_W),
        .DATA_BITS   (DATA_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl.rx_en),
        .div    (div),
        .rx_i   (rx_i),
        .done   (rx_done),
        .byte_o (rx_byte)
    );

    assign irq_tx    = flags.tx     && ctrl.tx_ie;
    assign irq_rx    = flags.rx     && ctrl.rx_ie;
    assign irq_txovr = flags.tx_ovr && ctrl.txovr_ie;
    assign irq_rxovr = flags.rx_ovr && ctrl.rxovr_ie;
    assign irq_any   = irq_tx || irq_rx || irq_txovr || irq_rxovr;

endmodule

// File: rtl/serlink_uart_chk.sv
module serlink_uart_chk
    import serlink_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_o,
    input logic              tx_pend,
    input logic              tx_take,
    input logic              irq_tx,
    input logic              irq_rx,
    input logic              irq_txovr,
    input logic              irq_rxovr,
    input logic              irq_any
);

    logic data_write;
    assign data_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));

    // R3
    take_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_o);

    // R6
    take_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> tx_pend);

    // R4
    take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_pend);

    // R4
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_write && !tx_pend) |=> tx_pend);

    // R12
    any_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_tx || irq_rx || irq_txovr || irq_rxovr) |-> !irq_any);

    // R12
    any_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx || irq_rxovr) |-> irq_any);

endmodule

bind serlink_uart serlink_uart_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .tx_o      (tx_o),
    .tx_pend   (tx_pend),
    .tx_take   (tx_take),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .irq_txovr (irq_txovr),
    .irq_rxovr (irq_rxovr),
    .irq_any   (irq_any)
);

// File: tb/serlink_uart_bench.sv
module serlink_uart_bench;

    localparam int DIV = 16;
    localparam logic [4:0] A_DATA  = 5'h00;
    localparam logic [4:0] A_STATE = 5'h04;
    localparam logic [4:0] A_CTRL  = 5'h08;
    localparam logic [4:0] A_INT   = 5'h0C;
    localparam logic [4:0] A_DIV   = 5'h10;

    // bit 8: 1 = receive vector, 0 = transmit vector; bits 7:0 = byte
    localparam logic [8:0] VEC [0:7] = '{
        9'h0A5, 9'h000, 9'h0FF, 9'h13C, 9'h1C3, 9'h101, 9'h080, 9'h1FE
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_i = 1'b1;
    logic        tx_o, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serlink_uart u_serlink_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_i      (rx_i),
        .tx_o      (tx_o),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx),
        .irq_txovr (irq_txovr),
        .irq_rxovr (irq_rxovr),
        .irq_any   (irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Call straight after the write that releases a byte; samples mid-bit
    task automatic tx_capture(output logic [9:0] bits);
        repeat (1 + DIV / 2) @(negedge clk);
        bits[0] = tx_o;
        for (int k = 1; k < 10; k++) begin
            repeat (DIV) @(negedge clk);
            bits[k] = tx_o;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rx_i = b[k];
            repeat (DIV) @(negedge clk);
        end
        rx_i = stop;
        repeat (DIV) @(negedge clk);
        rx_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [9:0]  bits;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tx line", {31'd0, tx_o}, 32'd1);
        check("R1 irq_any", {31'd0, irq_any}, 32'd0);
        bus_read(A_CTRL, d);  check("R1 ctrl", d, 32'h0);
        bus_read(A_STATE, d); check("R1 state", d, 32'h0);
        bus_read(A_INT, d);   check("R1 int", d, 32'h0);
        bus_read(A_DIV, d);   check("R1 div", d, 32'd16);

        // R2 register widths
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        bus_read(A_CTRL, d);  check("R2 ctrl width", d, 32'h3F);
        bus_write(A_DIV, 32'hFFFF_FFFF);
        bus_read(A_DIV, d);   check("R2 div width", d, 32'h1F_FFFF);
        bus_write(A_DIV, DIV);
        bus_write(A_CTRL, 32'h03);
        bus_read(A_INT, d);   check("R2 int untouched", d, 32'h0);

        // Vector table: R3 R6 transmit, R7 receive
        for (int i = 0; i < 8; i++) begin
            if (!VEC[i][8]) begin
                bus_write(A_DATA, {24'd0, VEC[i][7:0]});
                tx_capture(bits);
                check("R3 tx frame", {22'd0, bits}, {22'd0, 1'b1, VEC[i][7:0], 1'b0});
                idle(DIV);
                bus_read(A_INT, d); check("R6 tx flag", d, 32'h1);
                bus_write(A_INT, 32'h1);
            end else begin
                send_rx(VEC[i][7:0], 1'b1);
                idle(4);
                bus_read(A_STATE, d); check("R7 rx full", d, 32'h2);
                bus_read(A_INT, d);   check("R7 rx flag", d, 32'h2);
                bus_read(A_DATA, d);  check("R7 rx byte", d, {24'd0, VEC[i][7:0]});
                bus_read(A_STATE, d); check("R7 rx cleared", d, 32'h0);
                bus_write(A_INT, 32'h2);
            end
        end

        // R4 byte held while TX disabled
        bus_write(A_CTRL, 32'h02);
        bus_write(A_DATA, 32'h11);
        idle(5);
        bus_read(A_STATE, d); check("R4 held full", d, 32'h1);
        check("R4 line idle", {31'd0, tx_o}, 32'd1);

        // R5 overrun on second write
        bus_write(A_DATA, 32'h22);
        bus_read(A_STATE, d); check("R5 tx overrun state", d, 32'h5);
        bus_read(A_INT, d);   check("R5 tx overrun flag", d, 32'h4);
        bus_write(A_CTRL, 32'h03);
        tx_capture(bits);
        check("R5 first byte kept", {22'd0, bits}, {22'd0, 1'b1, 8'h11, 1'b0});
        idle(DIV);

        // R11 write-one-to-clear
        bus_write(A_INT, 32'h0);
        bus_read(A_INT, d);   check("R11 zero no effect", d, 32'h5);
        bus_write(A_INT, 32'h4);
        bus_read(A_INT, d);   check("R11 clear one bit", d, 32'h1);
        bus_read(A_STATE, d); check("R11 overrun sticky", d, 32'h4);
        bus_write(A_STATE, 32'h4);
        bus_read(A_STATE, d); check("R11 state clear", d, 32'h0);
        bus_write(A_INT, 32'h1);
        bus_read(A_INT, d);   check("R11 int clear", d, 32'h0);

        // R12 interrupt masking
        bus_write(A_DATA, 32'h5A);
        idle(2);
        check("R12 masked tx", {31'd0, irq_tx}, 32'd0);
        check("R12 masked any", {31'd0, irq_any}, 32'd0);
        bus_write(A_CTRL, 32'h07);
        check("R12 tx pin", {31'd0, irq_tx}, 32'd1);
        check("R12 any pin", {31'd0, irq_any}, 32'd1);
        check("R12 rx pin low", {31'd0, irq_rx}, 32'd0);
        bus_write(A_INT, 32'h1);
        check("R12 any after clear", {31'd0, irq_any}, 32'd0);
        idle(11 * DIV);
        bus_write(A_CTRL, 32'h03);

        // R8 bad stop bit
        send_rx(8'h66, 1'b0);
        idle(4);
        bus_read(A_STATE, d); check("R8 no byte", d, 32'h0);
        bus_read(A_INT, d);   check("R8 no flag", d, 32'h0);

        // R9 receive overrun
        bus_write(A_CTRL, 32'h23);
        send_rx(8'h12, 1'b1);
        idle(4);
        send_rx(8'h34, 1'b1);
        idle(4);
        bus_read(A_STATE, d); check("R9 overrun state", d, 32'hA);
        check("R9 rxovr pin", {31'd0, irq_rxovr}, 32'd1);
        bus_read(A_INT, d);   check("R9 overrun flag", d, 32'hA);
        bus_read(A_DATA, d);  check("R9 first byte kept", d, 32'h12);
        bus_write(A_STATE, 32'h8);
        bus_write(A_INT, 32'hA);
        bus_read(A_STATE, d); check("R9 cleaned", d, 32'h0);

        // R10 receive disabled
        bus_write(A_CTRL, 32'h01);
        send_rx(8'h77, 1'b1);
        idle(4);
        bus_read(A_STATE, d); check("R10 ignored state", d, 32'h0);
        bus_read(A_INT, d);   check("R10 ignored flag", d, 32'h0);

        // R13 false start, then a normal frame
        bus_write(A_CTRL, 32'h03);
        @(negedge clk);
        rx_i = 1'b0;
        idle(3);
        rx_i = 1'b1;
        idle(3 * DIV);
        bus_read(A_STATE, d); check("R13 glitch rejected", d, 32'h0);
        send_rx(8'h9C, 1'b1);
        idle(4);
        bus_read(A_DATA, d);  check("R13 recovers", d, 32'h9C);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule